// File: doc/BRIEF.md
# Sample FIFO With Interrupt and DMA Request Routing

This block buffers conversion results between a converter running at its own pace and a host that collects them in bursts. Each conversion word is 16 bits, left-justified. Up to 512 words are held in first-in, first-out order. The host side is a byte-wide register port. The host fetches each word from a single data address with two reads: the low byte comes first and the high byte second. The word leaves the queue on the second read.

The host can read a status byte, which gives the queue occupancy as active-low flags plus a sticky overflow bit. Reading the clear address empties the queue. A byte-wide configuration register picks one of four conditions: full, half full, acquisition done, or not empty. The chosen condition is routed to one of three interrupt request lines, to one of two DMA request lines, or to both. When an interrupt line and a DMA line are both enabled, the DMA line follows the condition and the interrupt line instead reports the host's DMA terminal count.

Top module: `sample_fifo_router`

## Requirements
- R1: The queue holds at most 512 words. A conversion write made while 512 words are stored is dropped, and the stored words keep their order and contents.
- R2: A read of data address 1 returns bits [7:0] of the oldest word, and the next such read returns bits [15:8]. The word is removed only after the second read, so the queue stays not-empty between the two reads.
- R3: Status address 0 reads these bits, active-low where noted:
  - bit0 = 1 when the queue is not empty.
  - bit1 = 1 when fewer than 256 words are stored.
  - bit2 = 1 when fewer than 512 words are stored.
  - bit3 = the overflow flag.
  - Bits 7:4 read 0.
  - After reset the status reads 0x06.
- R4: A host read of address 2 empties the queue, discards all stored words, clears the overflow flag and returns the byte phase to the low byte.
- R5: A conversion write while the queue is full sets the overflow flag. The flag stays set through later reads until a clear of the queue.
- R6: Config register bits [1:0] (written at address 2) select the request condition: 00 full, 01 at least half full (256 or more words), 10 the acquire-done input, 11 not empty.
- R7: Config bits [3:2] pick the interrupt line: 00 none, 01 irq_req[0], 10 irq_req[1], 11 irq_req[2]. At most one interrupt line is high.
- R8: Config bits [5:4] pick the DMA line: 00 none, 01 dma_req[0], 10 dma_req[1], 11 none (spare). At most one DMA line is high.
- R9: When the interrupt field is nonzero and the DMA field is 01 or 10, two things hold. The selected interrupt line follows dma_tc only. The selected DMA line follows the chosen condition.
- R10: A data read while the queue is empty returns 0x00, removes nothing and leaves the byte phase unchanged.
- R11: A conversion write in the same cycle as a clear read is discarded, and the queue is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_wr | input | 1 | Conversion word write strobe |
| conv_word | input | 16 | Left-justified conversion word |
| host_rd | input | 1 | Host register read strobe |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register address: 0 status, 1 data, 2 clear (read) / config (write) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the addressed register |
| acq_done | input | 1 | Acquisition-complete condition |
| dma_tc | input | 1 | Host DMA terminal count |
| irq_req | output | 3 | Decoded interrupt request lines |
| dma_req | output | 2 | Decoded DMA request lines |

## Verification
Several properties are checked by the assertions on every cycle:
- The occupancy never exceeds the capacity.
- A clear always leaves an empty queue and a low byte phase, even when it meets a write.
- A write into a full queue always raises the overflow flag.
- An empty data read never moves the byte phase.
- The request lines are never more than one-hot.
- Under dual enable, the interrupt line tracks the terminal count.

The bench scenarios cover what needs sequences to show:
- Word order across a full fill and drain.
- The dropped word missing from the drained stream.
- The active-low status values at the 256 and 512 boundaries.
- Each source and level encoding reaching the right line.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_DATA   = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;

    typedef enum logic [1:0] {
        SRC_FULL     = 2'b00,
        SRC_HALF     = 2'b01,
        SRC_ACQ      = 2'b10,
        SRC_NOTEMPTY = 2'b11
    } req_src_e;

    typedef struct packed {
        logic [1:0] dma_lvl;
        logic [1:0] irq_lvl;
        req_src_e   src;
    } route_cfg_t;

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } store_st_t;

    store_st_t st_d, st_q;
    logic      do_push, do_pop;
    logic [WIDTH-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && !clear && (st_q.cnt != FULL_CNT);
        do_pop  = pop && !clear && (st_q.cnt != '0);
        if (clear) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
            st_d.ovf  = 1'b0;
        end else begin
            if (push && (st_q.cnt == FULL_CNT)) st_d.ovf = 1'b1;
            if (do_push) st_d.wptr = next_ptr(st_q.wptr);
            if (do_pop)  st_d.rptr = next_ptr(st_q.rptr);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wptr] <= wdata;
    end

    assign head  = mem[st_q.rptr];
    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;

    // Occupancy never passes the capacity
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    // A clear empties the queue and drops the overflow flag
    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.cnt == '0) && !st_q.ovf);

    // A write into a full queue raises the sticky flag
    assert_full_write_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear && st_q.cnt == FULL_CNT) |=> st_q.ovf);

    // A write that meets a clear leaves nothing behind
    assert_clear_beats_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && clear) |=> (st_q.cnt == '0));

endmodule

// File: rtl/sfifo_byte_reader.sv
module sfifo_byte_reader (
    input  logic clk,
    input  logic rst_n,
    input  logic data_rd,
    input  logic clear,
    input  logic empty,
    output logic hi_phase,
    output logic pop
);
    typedef struct packed {
        logic hi;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        pop  = data_rd && !empty && st_q.hi;
        if (clear)                  st_d.hi = 1'b0;
        else if (data_rd && !empty) st_d.hi = !st_q.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_phase = st_q.hi;

    // The first byte of a word moves the phase to the high byte
    assert_low_then_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !empty && !clear && !st_q.hi) |=> st_q.hi);

    // Clearing the queue returns the phase to the low byte
    assert_phase_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !st_q.hi);

    // An empty data read leaves the phase alone
    assert_empty_read_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && empty && !clear) |=> $stable(st_q.hi));

endmodule

// File: rtl/sfifo_req_route.sv
module sfifo_req_route #(
    parameter int IRQ_N = 3,
    parameter int DRQ_N = 2,
    parameter int LVL_W = 2
) (
    input  sfifo_pkg::route_cfg_t cfg,
    input  logic             is_full,
    input  logic             is_half,
    input  logic             is_nonempty,
    input  logic             acq_done,
    input  logic             dma_tc,
    output logic [IRQ_N-1:0] irq_req,
    output logic [DRQ_N-1:0] dma_req
);
    import sfifo_pkg::*;

    logic flag, irq_on, dma_on, irq_src;

    always_comb begin
        case (cfg.src)
            SRC_FULL: flag = is_full;
            SRC_HALF: flag = is_half;
            SRC_ACQ:  flag = acq_done;
            default:  flag = is_nonempty;
        endcase
        irq_on  = (cfg.irq_lvl != '0);
        dma_on  = (cfg.dma_lvl != '0) && (cfg.dma_lvl <= LVL_W'(DRQ_N));
        irq_src = (irq_on && dma_on) ? dma_tc : flag;
    end

    for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
        assign irq_req[i] = irq_src && (cfg.irq_lvl == LVL_W'(i + 1));
    end

    for (genvar j = 0; j < DRQ_N; j++) begin : g_drq
        assign dma_req[j] = flag && (cfg.dma_lvl == LVL_W'(j + 1));
    end

endmodule

// File: rtl/sample_fifo_router.sv
module sample_fifo_router #(
    parameter int DEPTH  = 512,
    parameter int BYTE_W = 8,
    parameter int IRQ_N  = 3,
    parameter int DRQ_N  = 2,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_wr,
    input  logic [WORD_W-1:0] conv_word,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              acq_done,
    input  logic              dma_tc,
    output logic [IRQ_N-1:0]  irq_req,
    output logic [DRQ_N-1:0]  dma_req
);
    import sfifo_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
    localparam int CFG_W = $bits(route_cfg_t);

    route_cfg_t        cfg_d, cfg_q;
    logic              data_rd, clear, pop, hi_phase, ovf;
    logic              is_empty, is_full, is_half;
    logic [WORD_W-1:0] head;
    logic [CNT_W-1:0]  count;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^host_wdata[BYTE_W-1:CFG_W];
    assign data_rd  = host_rd && (host_addr == ADDR_DATA);
    assign clear    = host_rd && (host_addr == ADDR_CTRL);
    assign is_empty = (count == '0);
    assign is_full  = (count == FULL_CNT);
    assign is_half  = (count >= HALF_CNT);

    always_comb begin
        cfg_d = cfg_q;
        if (host_wr && (host_addr == ADDR_CTRL))
            cfg_d = route_cfg_t'(host_wdata[CFG_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    sfifo_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(conv_wr), .pop(pop), .clear(clear),
        .wdata(conv_word), .head(head), .count(count), .ovf(ovf)
    );

    sfifo_byte_reader u_reader (
        .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .clear(clear),
        .empty(is_empty), .hi_phase(hi_phase), .pop(pop)
    );

    sfifo_req_route #(.IRQ_N(IRQ_N), .DRQ_N(DRQ_N)) u_route (
        .cfg(cfg_q), .is_full(is_full), .is_half(is_half),
        .is_nonempty(!is_empty), .acq_done(acq_done), .dma_tc(dma_tc),
        .irq_req(irq_req), .dma_req(dma_req)
    );

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            ADDR_STATUS: host_rdata = {{(BYTE_W-4){1'b0}}, ovf, !is_full, !is_half, !is_empty};
            ADDR_DATA: if (!is_empty)
                host_rdata = hi_phase ? head[WORD_W-1:BYTE_W] : head[BYTE_W-1:0];
            default: host_rdata = '0;
        endcase
    end

    // At most one interrupt line is driven
    assert_irq_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req));

    // At most one DMA line is driven
    assert_drq_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_req));

    // With both paths enabled the interrupt reports only the terminal count
    assert_dual_enable_tc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q.irq_lvl != 2'b00) && (cfg_q.dma_lvl == 2'b01 || cfg_q.dma_lvl == 2'b10))
        |-> ((|irq_req) == dma_tc));

endmodule

// File: tb/tb_sample_fifo_router.sv
module tb_sample_fifo_router;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_wr = 1'b0;
    logic [15:0] conv_word = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        acq_done = 1'b0;
    logic        dma_tc = 1'b0;
    logic [2:0]  irq_req;
    logic [1:0]  dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] expq[$];

    always #4 clk = ~clk;

    sample_fifo_router dut (
        .clk(clk), .rst_n(rst_n), .conv_wr(conv_wr), .conv_word(conv_word),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .acq_done(acq_done),
        .dma_tc(dma_tc), .irq_req(irq_req), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: issues a conversion write and records the expected word
    task automatic push_word(input logic [15:0] w);
        @(negedge clk);
        conv_wr = 1'b1;
        conv_word = w;
        if (expq.size() < DEPTH) expq.push_back(w);
        @(negedge clk);
        conv_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1;
        host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1;
        host_addr = 2'd2;
        host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic clear_fifo();
        logic [7:0] d;
        host_read(2'd2, d);
        expq.delete();
    endtask

    task automatic status_is(input string tag, input logic [7:0] exp);
        logic [7:0] d;
        host_read(2'd0, d);
        chk(tag, d, exp);
    endtask

    // Monitor: fetches a word as two byte reads and compares with the queue head
    task automatic pop_and_check(input string tag);
        logic [7:0] lo, hi;
        logic [15:0] exp;
        host_read(2'd1, lo);
        host_read(2'd1, hi);
        exp = (expq.size() != 0) ? expq.pop_front() : 16'hxxxx;
        chk(tag, {hi, lo}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset state
        status_is("R3 reset status", 8'h06);
        chk("R7 reset irq", irq_req, 3'b000);
        chk("R8 reset drq", dma_req, 2'b00);

        // R2 byte order and pop timing
        push_word(16'hA1B2);
        push_word(16'h00FF);
        push_word(16'h7E81);
        status_is("R3 status three words", 8'h07);
        pop_and_check("R2 word 0");
        pop_and_check("R2 word 1");
        host_read(2'd1, d);
        chk("R2 low byte first", d, 8'h81);
        status_is("R2 still not empty mid word", 8'h07);
        host_read(2'd1, d);
        chk("R2 high byte second", d, 8'h7E);
        void'(expq.pop_front());
        status_is("R2 empty after high byte", 8'h06);

        // R10 empty read
        host_read(2'd1, d);
        chk("R10 empty read value", d, 8'h00);
        host_read(2'd1, d);
        chk("R10 empty read value again", d, 8'h00);
        push_word(16'h1234);
        pop_and_check("R10 phase unchanged by empty reads");

        // Half-full boundary and source / level encodings
        for (int i = 0; i < 255; i++) push_word(16'(i * 37 + 5));
        status_is("R3 status at 255 words", 8'h07);
        push_word(16'hBEEF);
        status_is("R3 status at 256 words", 8'h05);
        host_write(8'h05);
        chk("R6 R7 half source on line 0", irq_req, 3'b001);
        host_write(8'h09);
        chk("R7 level 10 on line 1", irq_req, 3'b010);
        host_write(8'h0D);
        chk("R7 level 11 on line 2", irq_req, 3'b100);
        host_write(8'h04);
        chk("R6 full source while not full", irq_req, 3'b000);
        host_write(8'h07);
        chk("R6 not-empty source", irq_req, 3'b001);
        host_write(8'h06);
        chk("R6 acquire source low", irq_req, 3'b000);
        acq_done = 1'b1;
        #1 chk("R6 acquire source high", irq_req, 3'b001);
        acq_done = 1'b0;

        // Fill to capacity and overflow
        for (int i = 0; i < 256; i++) push_word(16'(i * 91 + 3));
        status_is("R1 R3 status at 512 words", 8'h01);
        host_write(8'h04);
        chk("R6 full source at capacity", irq_req, 3'b001);
        push_word(16'hDEAD);
        status_is("R5 overflow flag set", 8'h09);
        chk("R1 model holds 512", expq.size(), 512);
        for (int i = 0; i < DEPTH; i++) pop_and_check("R1 drained order");
        status_is("R5 overflow sticky after drain", 8'h0E);

        // R4 clear
        push_word(16'h4444);
        clear_fifo();
        status_is("R4 clear empties and drops overflow", 8'h06);
        push_word(16'hAAAA);
        host_read(2'd1, d);
        chk("R4 low byte before clear", d, 8'hAA);
        clear_fifo();
        push_word(16'h5A3C);
        pop_and_check("R4 phase back to low byte");

        // R11 clear meets write
        push_word(16'h0101);
        @(negedge clk);
        conv_wr = 1'b1;
        conv_word = 16'h9999;
        host_rd = 1'b1;
        host_addr = 2'd2;
        @(negedge clk);
        conv_wr = 1'b0;
        host_rd = 1'b0;
        expq.delete();
        status_is("R11 write with clear discarded", 8'h06);

        // R8 DMA level decode
        push_word(16'h0F0F);
        host_write(8'h13);
        chk("R8 DMA level 01", dma_req, 2'b01);
        chk("R8 no irq with irq disabled", irq_req, 3'b000);
        host_write(8'h23);
        chk("R8 DMA level 10", dma_req, 2'b10);
        host_write(8'h33);
        chk("R8 spare level drives none", dma_req, 2'b00);

        // R9 both enabled
        host_write(8'h17);
        chk("R9 DMA follows flag", dma_req, 2'b01);
        chk("R9 irq quiet without tc", irq_req, 3'b000);
        dma_tc = 1'b1;
        #1 chk("R9 irq on tc", irq_req, 3'b001);
        dma_tc = 1'b0;
        clear_fifo();
        chk("R9 DMA drops when empty", dma_req, 2'b00);
        dma_tc = 1'b1;
        #1 chk("R9 irq on tc with flag low", irq_req, 3'b001);
        dma_tc = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule